// File: doc/BRIEF.md
# Cascadable Reloading Event Counter Group

This block holds six identical 16-bit event counters. Each one counts down by one for every qualified event. When a counter is at zero and one more event arrives, the counter loads its reload value, keeps counting, and gives a one-cycle underflow pulse. A counter that was written with n therefore underflows once every n+1 events.

Each counter takes its events from one of two sources. The first is its own asynchronous pin, with a choice of falling edges, rising edges, or both. The second is the underflow pulse of a fixed neighbour, which lets counters be chained into longer dividers. The six counters form two rings of three. Counter i listens to counter i-1, with two exceptions: counter 0 listens to counter 2, and counter 3 listens to counter 5.

Software writes a counter through a shared data bus and a per-channel write strobe. Whether a write also reaches the live count depends on the channel state. A write reaches the live count while the channel is stopped, and after start until the first event is counted. After that first event, a write only replaces the reload value.

Top module: `evc_group`

## Requirements
- R1: While its run bit is 1, a channel's counter decreases by one on each qualified event.
- R2: When an event arrives with the counter at 0, the counter takes the reload value and `uf_o` of that channel is high for exactly one cycle. A channel written with n therefore pulses once per n+1 events.
- R3: While its run bit is 0, a channel ignores all events and its counter holds its value.
- R4: A write while stopped, or while running before the first event since start, sets both the counter and the reload value to the written data.
- R5: A write after the first counted event since start changes only the reload value. The counter keeps counting, and the new value enters the counter at the next underflow.
- R6: `rd_data_o` slice i (bits 16i+15..16i) always shows the current counter of channel i.
- R7: With source select 0, the pin passes through a two-flop synchronizer and the 2-bit edge code selects the counted edges: 00 falling, 01 rising, 10 both. The counter reflects a pin change no later than the third rising clock edge after it.
- R8: Edge code 11 with source select 0 counts nothing.
- R9: With source select 1, channel i counts the underflow pulses of channel i-1, except that channel 0 uses channel 2 and channel 3 uses channel 5. The edge code is ignored in this case.
- R10: Reset clears every counter, every reload value, the first-event flags and all underflow outputs.
- R11: Clearing the run bit rearms the first-event flag, so the next write after a restart reaches the counter again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_i | input | 6 | Asynchronous event pins, one per channel |
| run_i | input | 6 | Run enable, one per channel |
| pol_i | input | 12 | Edge code, 2 bits per channel (bits 2i+1..2i) |
| src_sel_i | input | 6 | Source select per channel: 0 pin, 1 neighbour underflow |
| wr_en_i | input | 6 | Write strobe per channel |
| wr_data_i | input | 16 | Shared write data |
| rd_data_o | output | 96 | Counter value of every channel, 16 bits each |
| uf_o | output | 6 | One-cycle underflow pulse per channel |

## Verification
The assertions assume three things about the control inputs. `run_i`, `wr_en_i`, `wr_data_i` and the mode inputs are synchronous to the clock and settle between edges. A pin level must be held for at least two clock cycles, so that the synchronizer turns each edge into exactly one strobe. The stimulus changes every input on the falling clock edge and holds every pin level for six cycles, which also lets a chained underflow ripple through two neighbours before a value is read. Events and writes are never made to coincide on the same channel, so each count comes from a single cause.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/evc_edge_det.sv
module evc_edge_det
  import evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      strobe_o
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DEPTH-2:0], pin_i};
  end

  assign rise = sh_q[DEPTH-2] & ~sh_q[DEPTH-1];
  assign fall = ~sh_q[DEPTH-2] & sh_q[DEPTH-1];

  always_comb begin
    unique case (sel_i)
      EDGE_FALL: strobe_o = fall;
      EDGE_RISE: strobe_o = rise;
      EDGE_BOTH: strobe_o = rise | fall;
      default:   strobe_o = 1'b0; // reserved code counts nothing
    endcase
  end
endmodule

// File: rtl/evc_core.sv
module evc_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         ev_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, rld_q;
  logic seen_q, uf_q;
  logic ev, wr_cnt, zero;

  assign ev     = run_i & ev_i;
  assign wr_cnt = wr_en_i & (~run_i | ~seen_q);
  assign zero   = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      seen_q <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      uf_q <= ev & zero & ~wr_cnt;
      if (wr_en_i) rld_q <= wr_data_i;
      if (!run_i)  seen_q <= 1'b0;
      else if (ev) seen_q <= 1'b1;
      // counter-loading write takes the cycle; a coincident event is consumed
      if (wr_cnt)  cnt_q <= wr_data_i;
      else if (ev) cnt_q <= zero ? (wr_en_i ? wr_data_i : rld_q) : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign uf_o  = uf_q;

  assert_hold_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> cnt_q == $past(cnt_q));

  assert_decrement_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ev_i && !zero && !wr_en_i) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_uf_at_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q |-> ($past(cnt_q) == '0 && $past(run_i) && $past(ev_i)));

  assert_reload_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && run_i && seen_q && !ev_i) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/evc_channel.sv
module evc_channel
  import evc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_i,
  input  logic         chain_i,
  input  logic         run_i,
  input  logic [1:0]   pol_i,
  input  logic         src_sel_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic pin_ev, ev;

  evc_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (ext_i),
    .sel_i    (edge_sel_e'(pol_i)),
    .strobe_o (pin_ev)
  );

  assign ev = src_sel_i ? chain_i : pin_ev;

  evc_core #(.W(W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .ev_i      (ev),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_o),
    .uf_o      (uf_o)
  );
endmodule

// File: rtl/evc_group.sv
module evc_group #(
  parameter int W    = 16,
  parameter int N    = 6,
  parameter int RING = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   ext_i,
  input  logic [N-1:0]   run_i,
  input  logic [2*N-1:0] pol_i,
  input  logic [N-1:0]   src_sel_i,
  input  logic [N-1:0]   wr_en_i,
  input  logic [W-1:0]   wr_data_i,
  output logic [N*W-1:0] rd_data_o,
  output logic [N-1:0]   uf_o
);
  logic [N-1:0] uf;

  for (genvar i = 0; i < N; i++) begin : g_ch
    // neighbour: previous channel within the ring, wrapping to the ring's last
    localparam int NB = (i % RING == 0) ? i + RING - 1 : i - 1;

    evc_channel #(.W(W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ext_i     (ext_i[i]),
      .chain_i   (uf[NB]),
      .run_i     (run_i[i]),
      .pol_i     (pol_i[2*i +: 2]),
      .src_sel_i (src_sel_i[i]),
      .wr_en_i   (wr_en_i[i]),
      .wr_data_i (wr_data_i),
      .cnt_o     (rd_data_o[W*i +: W]),
      .uf_o      (uf[i])
    );
  end

  assign uf_o = uf;
endmodule

// File: tb/tb_evc_group.sv
module tb_evc_group;
  localparam int W = 16;
  localparam int N = 6;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   ext = '0, run = '0, src = '0, wr = '0;
  logic [2*N-1:0] pol = '0;
  logic [W-1:0]   wdata = '0;
  logic [N*W-1:0] rd;
  logic [N-1:0]   uf;

  int total = 0, bad = 0;
  int uf_seen [N];
  bit done = 1'b0;

  always #2 clk = ~clk;

  evc_group #(.W(W), .N(N), .RING(3)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_i(ext), .run_i(run), .pol_i(pol),
    .src_sel_i(src), .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rd), .uf_o(uf)
  );

  initial for (int i = 0; i < N; i++) uf_seen[i] = 0;
  always @(negedge clk) for (int i = 0; i < N; i++) if (uf[i]) uf_seen[i]++;

  // {edge code, drop after rising edge, drop after full pulse}
  localparam logic [5:0] VEC [4] = '{
    {2'b00, 2'd0, 2'd1},
    {2'b01, 2'd1, 2'd1},
    {2'b10, 2'd1, 2'd2},
    {2'b11, 2'd0, 2'd0}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int cnt(int ch);
    return int'(rd[W*ch +: W]);
  endfunction

  task automatic write(int ch, int val);
    wdata = W'(val);
    wr[ch] = 1'b1;
    tick(1);
    wr[ch] = 1'b0;
    tick(1);
  endtask

  task automatic pin(int ch, bit lvl);
    ext[ch] = lvl;
    tick(6);
  endtask

  task automatic pulse(int ch);
    pin(ch, 1'b1);
    pin(ch, 1'b0);
  endtask

  initial begin
    int u;
    tick(3);
    for (int i = 0; i < N; i++) chk("R10 reset counter", cnt(i), 0);
    chk("R10 reset uf", int'(uf), 0);
    rst_ni = 1'b1;
    tick(2);

    // edge code table on channel 1
    for (int k = 0; k < 4; k++) begin
      run[1] = 1'b0;
      pol[3:2] = VEC[k][5:4];
      tick(2);
      write(1, 100);
      chk("R4 stopped write", cnt(1), 100);
      run[1] = 1'b1;
      tick(1);
      pin(1, 1'b1);
      chk($sformatf("R7 R8 code %0d rise", k), cnt(1), 100 - int'(VEC[k][3:2]));
      pin(1, 1'b0);
      chk($sformatf("R7 R8 code %0d pulse", k), cnt(1), 100 - int'(VEC[k][1:0]));
      chk("R6 readback", cnt(1), 100 - int'(VEC[k][1:0]));
    end

    // underflow period n+1 with n=2
    run[1] = 1'b0;
    pol[3:2] = 2'b01;
    tick(1);
    write(1, 2);
    run[1] = 1'b1;
    tick(1);
    u = uf_seen[1];
    pulse(1); pulse(1);
    chk("R1 down to zero", cnt(1), 0);
    chk("R2 no uf before wrap", uf_seen[1] - u, 0);
    pulse(1);
    chk("R2 reload at underflow", cnt(1), 2);
    chk("R2 single uf pulse", uf_seen[1] - u, 1);

    // write after first event: reload only
    write(1, 7);
    chk("R5 counter untouched", cnt(1), 2);
    pulse(1); pulse(1);
    chk("R5 old value still counting", cnt(1), 0);
    pulse(1);
    chk("R5 new reload taken", cnt(1), 7);

    // restart rearms first-event flag
    run[1] = 1'b0;
    tick(1);
    write(1, 9);
    chk("R4 write while stopped", cnt(1), 9);
    run[1] = 1'b1;
    tick(1);
    write(1, 5);
    chk("R11 write before first event", cnt(1), 5);
    pulse(1);
    chk("R1 decrement", cnt(1), 4);
    write(1, 30);
    chk("R5 write after first event", cnt(1), 4);

    // stopped channel ignores events
    run[1] = 1'b0;
    tick(1);
    pulse(1); pulse(1);
    chk("R3 stopped holds", cnt(1), 4);

    // cascade: ch1 -> ch2 -> ch0; ch3 watches ch5 only
    write(1, 0);
    run[1] = 1'b1;
    src[2] = 1'b1; pol[5:4] = 2'b11;
    src[0] = 1'b1;
    src[3] = 1'b1;
    write(2, 1);
    write(0, 5);
    write(3, 5);
    run[2] = 1'b1; run[0] = 1'b1; run[3] = 1'b1;
    tick(1);
    u = uf_seen[2];
    pulse(1);
    chk("R9 chained decrement", cnt(2), 0);
    pulse(1);
    chk("R9 chained reload", cnt(2), 1);
    chk("R9 chained uf", uf_seen[2] - u, 1);
    chk("R9 ring wrap ch0", cnt(0), 4);
    chk("R9 ch3 not fed by ch2", cnt(3), 5);

    // reset while running
    rst_ni = 1'b0;
    tick(2);
    for (int i = 0; i < N; i++) chk("R10 reset mid-run", cnt(i), 0);
    rst_ni = 1'b1;
    tick(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule